// File: doc/BRIEF.md
# Serial Command and Write-Beat Deframer

This block sits at the memory end of a narrow, one-way link that carries commands, addresses and write data from a memory controller. Ten lanes are sampled on every clock, one transfer per cycle. A start marker flags the first transfer of a frame. Twelve transfers make one 120-bit frame. Once a frame is complete, the block checks its CRC. It then presents the frame's command/address word on one output and the frame's write beat on another. The write beat is 64 data bits plus 8 check bits.

A full 32-byte write spans four frames. Each frame carries one beat, tagged with a beat index and a first-beat flag. The block gathers the four beats in order and presents the completed line in the same cycle as the fourth beat. A frame with a bad CRC is dropped whole, and so is any line still being gathered. A beat whose index is out of order stops the line being gathered and raises a sequence error.

Top module: `cad_deframer`

## Requirements
- R1: After reset, `ca_valid`, `beat_valid`, `line_valid`, `crc_err` and `seq_err` are all low.
- R2: The transfer sampled with `frame_sof` high becomes frame bits 9:0, and transfer k becomes bits 10k+9:10k. Bits 99:72 are the command/address word. For a frame whose CRC matches, that word appears on `ca_word`, and `ca_valid` pulses in the cycle after the twelfth transfer.
- R3: Frame bit 102 marks a data-bearing frame, and bits 71:0 hold its beat. An accepted beat appears on `beat_word` with a `beat_valid` pulse, in the same cycle as its `ca_valid`.
- R4: The CRC runs over frame bits 0 to 103, taken in ascending order. It uses polynomial 0x1021 with a seed of 0xFFFF. Each step XORs the incoming bit with the register's top bit, shifts left, and applies the polynomial when that XOR is 1. The result is compared with bits 119:104, where bit 104 holds CRC bit 0. On a mismatch, `crc_err` pulses and no command, beat or line is output for that frame.
- R5: A CRC mismatch discards any line being gathered, so the next beat accepted must have index 0.
- R6: Frame bits 101:100 hold the beat index and bit 103 holds the first-beat flag. A data frame is accepted only if its index equals the expected count and its flag equals (expected count == 0). The expected count starts at 0 after reset, after a completed line and after any error. A rejected data frame still outputs its command word. It pulses `seq_err`, outputs no beat, and resets the expected count. An accepted beat shows its index on `beat_idx`.
- R7: When the beat with index 3 is accepted, `line_valid` pulses in the same cycle. `line_word` then holds beat k at bits 72k+71:72k.
- R8: A `frame_sof` seen before the twelfth transfer of a frame, including on the twelfth transfer itself, abandons the partial frame without any output, and a new frame starts.
- R9: A frame without the data mark outputs only its command word and leaves the line being gathered untouched.
- R10: Every strobe is a one-cycle pulse. Each frame produces at most one command pulse or one CRC error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lane_in | input | 10 | Lane values of the current transfer |
| frame_sof | input | 1 | High on the first transfer of a frame |
| ca_valid | output | 1 | Command/address word valid pulse |
| ca_word | output | 28 | Command/address word |
| beat_valid | output | 1 | Accepted write beat pulse |
| beat_idx | output | 2 | Index of the accepted beat |
| beat_word | output | 72 | Write beat, 64 data plus 8 check bits |
| line_valid | output | 1 | Completed 32-byte line pulse |
| line_word | output | 288 | Four beats of the completed line |
| crc_err | output | 1 | Frame dropped for CRC mismatch |
| seq_err | output | 1 | Beat index or first-beat flag out of order |

## Verification
The completion of a line coincides with the command word and the fourth beat of the same frame. A start marker can also land on the twelfth transfer, which is exactly where a frame would otherwise finish. The bench provokes the first by sending gathered lines, both back to back and with a command-only frame in the middle. It provokes the second by cutting frames short after five and after eleven transfers. A behavioural model built on bit queues predicts every strobe and word on each clock. Line counts after each scenario confirm that aborted and abandoned gathers never produce a line.

// File: rtl/cad_deframer_pkg.sv
package cad_deframer_pkg;
  // header nibble carried in each frame, most significant field first
  typedef struct packed {
    logic       first;
    logic       has_data;
    logic [1:0] idx;
  } hdr_t;

  localparam int HDR_W = $bits(hdr_t);
  localparam int IDX_W = 2;
endpackage

// File: rtl/cad_deframer_collect.sv
module cad_deframer_collect #(
  parameter int LANES = 10,
  parameter int XFERS = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       lane_in,
  input  logic                   frame_sof,
  output logic                   frame_done,
  output logic [LANES*XFERS-1:0] frame_bits
);
  localparam int FW = LANES * XFERS;
  localparam int HW = FW - LANES;
  localparam int CW = $clog2(XFERS);

  logic [HW-1:0] hist_q, hist_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          shift_en;

  always_comb begin
    shift_en   = frame_sof | act_q;
    hist_d     = {lane_in, hist_q[HW-1:LANES]};
    frame_done = act_q & ~frame_sof & (cnt_q == CW'(XFERS - 1));
    frame_bits = {lane_in, hist_q};
    cnt_d      = cnt_q;
    act_d      = act_q;
    if (frame_sof) begin
      cnt_d = CW'(1);
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == CW'(XFERS - 1)) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk) begin
    if (shift_en) hist_q <= hist_d;
  end
endmodule

// File: rtl/cad_deframer_crc.sv
module cad_deframer_crc #(
  parameter int                 DW    = 104,
  parameter int                 CRC_W = 16,
  parameter logic [CRC_W-1:0]   POLY  = 16'h1021,
  parameter logic [CRC_W-1:0]   SEED  = 16'hFFFF
) (
  input  logic [DW-1:0]    data_in,
  output logic [CRC_W-1:0] crc_out
);
  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = SEED;
    for (int i = 0; i < DW; i++) begin
      fb = c[CRC_W-1] ^ data_in[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc_out = c;
  end
endmodule

// File: rtl/cad_deframer_assemble.sv
module cad_deframer_assemble
  import cad_deframer_pkg::*;
#(
  parameter int CA_W   = 28,
  parameter int BEAT_W = 72
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_done,
  input  logic                   crc_ok,
  input  logic [CA_W-1:0]        ca_in,
  input  hdr_t                   hdr,
  input  logic [BEAT_W-1:0]      beat_in,
  output logic                   ca_valid,
  output logic [CA_W-1:0]        ca_word,
  output logic                   beat_valid,
  output logic [IDX_W-1:0]       beat_idx,
  output logic [BEAT_W-1:0]      beat_word,
  output logic                   line_valid,
  output logic [(1<<IDX_W)*BEAT_W-1:0] line_word,
  output logic                   crc_err,
  output logic                   seq_err
);
  localparam int                BEATS = 1 << IDX_W;
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(BEATS - 1);

  logic [IDX_W-1:0] exp_q, exp_d;
  logic good, bad, seq_ok, take, reject;

  always_comb begin
    good   = frame_done & crc_ok;
    bad    = frame_done & ~crc_ok;
    seq_ok = (hdr.idx == exp_q) & (hdr.first == (exp_q == '0));
    take   = good & hdr.has_data & seq_ok;
    reject = good & hdr.has_data & ~seq_ok;
    exp_d  = exp_q;
    if (bad | reject)  exp_d = '0;
    else if (take)     exp_d = exp_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q      <= '0;
      ca_valid   <= 1'b0;
      beat_valid <= 1'b0;
      line_valid <= 1'b0;
      crc_err    <= 1'b0;
      seq_err    <= 1'b0;
    end else begin
      exp_q      <= exp_d;
      ca_valid   <= good;
      beat_valid <= take;
      line_valid <= take & (exp_q == LAST);
      crc_err    <= bad;
      seq_err    <= reject;
    end
  end

  always_ff @(posedge clk) begin
    if (good) ca_word <= ca_in;
    if (take) begin
      beat_word <= beat_in;
      beat_idx  <= exp_q;
    end
  end

  for (genvar k = 0; k < BEATS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (take && exp_q == IDX_W'(k)) line_word[k*BEAT_W +: BEAT_W] <= beat_in;
    end
  end
endmodule

// File: rtl/cad_deframer.sv
module cad_deframer
  import cad_deframer_pkg::*;
#(
  parameter int               LANES    = 10,
  parameter int               XFERS    = 12,
  parameter int               BEAT_W   = 72,
  parameter int               CA_W     = 28,
  parameter int               CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_SEED = 16'hFFFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANES-1:0]     lane_in,
  input  logic                 frame_sof,
  output logic                 ca_valid,
  output logic [CA_W-1:0]      ca_word,
  output logic                 beat_valid,
  output logic [IDX_W-1:0]     beat_idx,
  output logic [BEAT_W-1:0]    beat_word,
  output logic                 line_valid,
  output logic [(1<<IDX_W)*BEAT_W-1:0] line_word,
  output logic                 crc_err,
  output logic                 seq_err
);
  localparam int FW     = LANES * XFERS;
  localparam int CA_LO  = BEAT_W;
  localparam int HDR_LO = CA_LO + CA_W;
  localparam int CRC_LO = HDR_LO + HDR_W;

  logic          rst_meta_q, rst_sync_q;
  logic          frame_done;
  logic [FW-1:0] frame_bits;
  logic [CRC_W-1:0] crc_calc;
  logic          crc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cad_deframer_collect #(.LANES(LANES), .XFERS(XFERS)) u_collect (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .lane_in    (lane_in),
    .frame_sof  (frame_sof),
    .frame_done (frame_done),
    .frame_bits (frame_bits)
  );

  cad_deframer_crc #(.DW(CRC_LO), .CRC_W(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .data_in (frame_bits[CRC_LO-1:0]),
    .crc_out (crc_calc)
  );

  assign crc_ok = (crc_calc == frame_bits[CRC_LO +: CRC_W]);

  cad_deframer_assemble #(.CA_W(CA_W), .BEAT_W(BEAT_W)) u_assemble (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .frame_done (frame_done),
    .crc_ok     (crc_ok),
    .ca_in      (frame_bits[CA_LO +: CA_W]),
    .hdr        (hdr_t'(frame_bits[HDR_LO +: HDR_W])),
    .beat_in    (frame_bits[BEAT_W-1:0]),
    .ca_valid   (ca_valid),
    .ca_word    (ca_word),
    .beat_valid (beat_valid),
    .beat_idx   (beat_idx),
    .beat_word  (beat_word),
    .line_valid (line_valid),
    .line_word  (line_word),
    .crc_err    (crc_err),
    .seq_err    (seq_err)
  );
endmodule

// File: rtl/cad_deframer_chk.sv
module cad_deframer_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_sof,
  input logic             ca_valid,
  input logic             beat_valid,
  input logic [IDX_W-1:0] beat_idx,
  input logic             line_valid,
  input logic             crc_err,
  input logic             seq_err
);
  a_r4_crc_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> !ca_valid && !beat_valid && !line_valid);

  a_r6_seq_err_keeps_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> ca_valid && !beat_valid);

  a_r3_beat_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> ca_valid);

  a_r7_line_on_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> beat_valid && (beat_idx == IDX_W'((1 << IDX_W) - 1)));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_valid || crc_err) |=> !(ca_valid || crc_err));

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ca_valid, crc_err}) <= 1);

  a_r8_sof_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sof |=> !ca_valid && !crc_err);
endmodule

bind cad_deframer cad_deframer_chk #(.IDX_W(cad_deframer_pkg::IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_sof  (frame_sof),
  .ca_valid   (ca_valid),
  .beat_valid (beat_valid),
  .beat_idx   (beat_idx),
  .line_valid (line_valid),
  .crc_err    (crc_err),
  .seq_err    (seq_err)
);

// File: tb/cad_deframer_bench.sv
module cad_deframer_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [9:0]   lane_in;
  logic         frame_sof;
  logic         ca_valid, beat_valid, line_valid, crc_err, seq_err;
  logic [27:0]  ca_word;
  logic [1:0]   beat_idx;
  logic [71:0]  beat_word;
  logic [287:0] line_word;

  int checks = 0, errors = 0, lines_seen = 0;
  bit mdl_on = 0, done_flag = 0;

  always #10 clk = ~clk;

  cad_deframer u_cad_deframer (
    .clk(clk), .rst_n(rst_n), .lane_in(lane_in), .frame_sof(frame_sof),
    .ca_valid(ca_valid), .ca_word(ca_word), .beat_valid(beat_valid),
    .beat_idx(beat_idx), .beat_word(beat_word), .line_valid(line_valid),
    .line_word(line_word), .crc_err(crc_err), .seq_err(seq_err)
  );

  function automatic logic [15:0] ref_crc(logic [119:0] f);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < 104; i++) begin
      if (c[15] ^ f[i]) c = (c << 1) ^ 16'h1021;
      else              c = c << 1;
    end
    return c;
  endfunction

  function automatic logic [119:0] mk(logic [27:0] ca, int idx, bit first,
                                      bit has, logic [71:0] beat, bit bad);
    logic [119:0] f;
    f[71:0]    = beat;
    f[99:72]   = ca;
    f[101:100] = idx[1:0];
    f[102]     = has;
    f[103]     = first;
    f[119:104] = ref_crc(f) ^ (bad ? 16'h0001 : 16'h0000);
    return f;
  endfunction

  // behavioural reference model
  bit           q_bits[$];
  bit           m_act = 0;
  int           m_exp = 0;
  logic [71:0]  m_line [4];
  logic         e_ca_v, e_beat_v, e_line_v, e_crc, e_seq;
  logic [27:0]  e_ca;
  logic [1:0]   e_idx;
  logic [71:0]  e_beat;
  logic [287:0] e_line;

  always @(posedge clk) begin
    e_ca_v = 0; e_beat_v = 0; e_line_v = 0; e_crc = 0; e_seq = 0;
    if (mdl_on) begin
      if (frame_sof) begin q_bits.delete(); m_act = 1; end
      if (m_act) begin
        for (int l = 0; l < 10; l++) q_bits.push_back(lane_in[l]);
        if (q_bits.size() == 120) begin
          logic [119:0] f;
          for (int i = 0; i < 120; i++) f[i] = q_bits[i];
          q_bits.delete();
          m_act = 0;
          if (ref_crc(f) != f[119:104]) begin
            e_crc = 1; m_exp = 0;
          end else begin
            e_ca_v = 1; e_ca = f[99:72];
            if (f[102]) begin
              if (int'(f[101:100]) == m_exp && f[103] == (m_exp == 0)) begin
                e_beat_v = 1; e_idx = f[101:100]; e_beat = f[71:0];
                m_line[m_exp] = f[71:0];
                if (m_exp == 3) begin
                  e_line_v = 1;
                  e_line = {m_line[3], m_line[2], m_line[1], m_line[0]};
                  m_exp = 0;
                end else m_exp++;
              end else begin
                e_seq = 1; m_exp = 0;
              end
            end
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [287:0] act, logic [287:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (mdl_on) begin
      chk(ca_valid === e_ca_v, "R2", "ca_valid", ca_valid, e_ca_v);
      if (e_ca_v) chk(ca_word === e_ca, "R2", "ca_word", ca_word, e_ca);
      chk(beat_valid === e_beat_v, "R3", "beat_valid", beat_valid, e_beat_v);
      if (e_beat_v) begin
        chk(beat_word === e_beat, "R3", "beat_word", beat_word, e_beat);
        chk(beat_idx === e_idx, "R6", "beat_idx", beat_idx, e_idx);
      end
      chk(line_valid === e_line_v, "R7", "line_valid", line_valid, e_line_v);
      if (e_line_v) chk(line_word === e_line, "R7", "line_word", line_word, e_line);
      chk(crc_err === e_crc, "R4", "crc_err", crc_err, e_crc);
      chk(seq_err === e_seq, "R6", "seq_err", seq_err, e_seq);
      if (line_valid === 1'b1) lines_seen++;
    end
  end

  task automatic send(logic [119:0] f, int n = 12);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      lane_in   = f[10*k +: 10];
      frame_sof = (k == 0);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frame_sof = 0;
      lane_in   = 10'($urandom);
    end
  endtask

  function automatic logic [71:0] rbeat();
    return {8'($urandom), 32'($urandom), 32'($urandom)};
  endfunction

  task automatic dframe(int idx, bit first, bit has = 1, bit bad = 0, int n = 12);
    send(mk(28'($urandom), idx, first, has, rbeat(), bad), n);
  endtask

  task automatic full_line(int gap);
    for (int i = 0; i < 4; i++) begin
      dframe(i, i == 0);
      if (gap > 0) idle(gap);
    end
  endtask

  task automatic lines_are(int want, string req);
    idle(3);
    chk(lines_seen == want, req, "line count", 288'(lines_seen), 288'(want));
  endtask

  initial begin
    rst_n = 1; lane_in = '0; frame_sof = 0;
    #5 rst_n = 0;
    repeat (4) @(negedge clk);
    // R1: strobes low in reset
    chk({ca_valid, beat_valid, line_valid, crc_err, seq_err} === 5'b0, "R1",
        "strobes in reset", {ca_valid, beat_valid, line_valid, crc_err, seq_err}, 0);
    rst_n = 1;
    idle(4);
    chk({ca_valid, beat_valid, line_valid, crc_err, seq_err} === 5'b0, "R1",
        "strobes after release", {ca_valid, beat_valid, line_valid, crc_err, seq_err}, 0);
    mdl_on = 1;
    idle(2);

    full_line(2);                       // R2 R3 R7 with gaps
    lines_are(1, "R7");

    // R9: command-only frame inside a line
    dframe(0, 1); dframe(0, 0, 0); dframe(1, 0); dframe(2, 0); dframe(3, 0);
    lines_are(2, "R9");

    // R5: CRC failure drops partial line, index 2 afterwards is out of order
    dframe(0, 1); dframe(1, 0); dframe(2, 0, 1, 1); dframe(2, 0);
    dframe(0, 0, 0, 1);                 // R4 bad command-only frame
    full_line(0);
    lines_are(3, "R5");

    // R6: skipped index, then wrong first flag
    dframe(0, 1); dframe(2, 0); dframe(0, 0); dframe(1, 1);
    full_line(1);
    lines_are(4, "R6");

    // R8: frame cut after 5 and after 11 transfers
    dframe(0, 1); dframe(1, 0, 1, 0, 5); dframe(1, 0);
    dframe(2, 0, 1, 0, 11); dframe(2, 0); dframe(3, 0);
    lines_are(5, "R8");

    full_line(0);                       // R10 back to back
    full_line(0);
    lines_are(7, "R10");

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule